// File: doc/BRIEF.md
# Display Fetch Address Generator

This block produces the DWORD addresses that a display engine uses to read a frame buffer while a frame is being shown. Software programs a frame start offset, a line pitch in DWORDs, and the number of DWORD fetches in each line. Display timing logic then drives three strobes. The frame strobe re-arms the block. The line strobe opens a new display line. The advance strobe asks for the next fetch address. Each accepted advance raises a one-cycle valid flag alongside the address.

Three legacy display modes change the address sequence.

- **Split screen:** with split-screen compare on, the line whose number equals the programmed compare line starts from address zero. The lines after it step onward from zero.
- **Chain-4:** in chain-4 mode only every fourth DWORD is read. The number of fetches per line does not change.
- **Line doubling:** with line doubling on, every odd display line fetches the same source line as the even line before it. The frame buffer therefore holds half as many source lines as there are display lines. A flag marks such repeated lines.

Top module: `dispFetchAddr`

## Requirements
- R1: On a cycle with `frameStart` high, the line counter is cleared and `fetchAddr` shows `startOffset` from the next cycle on. The first line opened after that is display line 0 and fetches from `startOffset`. `repeatLine` goes low and no fetch credit remains.
- R2: Each later line start opens display line number (previous + 1), taken modulo 2^LINE_W. Unless R5 or R6 applies, that line's base is the previous line's base plus `lineDelta`, and `fetchAddr` shows it from the next cycle on.
- R3: After a line start, the line grants exactly `dwordsPerLine` fetches. On each cycle with `fetchAdv` high and credit left, `fetchValid` is high in that same cycle with the current `fetchAddr`, and the address steps by one DWORD for the next cycle. An advance with no credit left leaves `fetchValid` low and the address unchanged.
- R4: With `chain4En` high, each granted fetch steps the address by 4 DWORDs instead of 1. The number of fetches per line is still `dwordsPerLine`.
- R5: With `splitEn` high, the line whose display number equals `splitLine` takes base address 0. Later lines advance from that base, following R2 and R6.
- R6: With `lineDblEn` high, an odd-numbered display line (bit 0 of the line number is 1) that is not a split match reuses the previous line's base, and `repeatLine` is high for that line. Even lines advance by `lineDelta`. Without line doubling, `repeatLine` is low.
- R7: `frameStart` takes priority over `lineStart`, and `lineStart` takes priority over `fetchAdv`. An advance in a cycle that carries either of the other strobes is not granted.
- R8: Address arithmetic wraps modulo 2^ADDR_W. This applies to both the per-fetch step and the line-delta advance.
- R9: After reset, `fetchAddr` is 0, `fetchValid` and `repeatLine` are low, and no fetch is granted before the first line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame start strobe |
| lineStart | input | 1 | Display line start strobe |
| fetchAdv | input | 1 | Request for the next fetch address |
| startOffset | input | ADDR_W | Frame start offset in DWORDs |
| lineDelta | input | ADDR_W | Line pitch in DWORDs |
| dwordsPerLine | input | CNT_W | Fetches granted per line |
| splitLine | input | LINE_W | Split-screen compare line number |
| splitEn | input | 1 | Split-screen compare enable |
| chain4En | input | 1 | Chain-4 skip enable |
| lineDblEn | input | 1 | Line doubling enable |
| fetchAddr | output | ADDR_W | Current fetch DWORD address |
| fetchValid | output | 1 | Fetch granted this cycle |
| repeatLine | output | 1 | Current line repeats the previous source line |

## Verification
`fetchValid` is a same-cycle decode of `fetchAdv` and the stored credit. `fetchAddr` and `repeatLine` take their new values one clock after the strobe that changes them.

The bench drives inputs on the falling edge and compares the outputs one time unit later, before the rising edge, against a behavioural model. That model holds the state as it stood before that edge. The bench updates the model only after the rising edge. Each comparison therefore checks the valid flag for the stimulus of the current cycle and the address and repeat flag produced by the previous cycle's strobes.

// File: rtl/dispFetchPkg.sv
package dispFetchPkg;

  typedef enum logic [1:0] {
    BASE_HOLD = 2'd0,
    BASE_ADV  = 2'd1,
    BASE_ZERO = 2'd2
  } baseSel_e;

  typedef struct packed {
    logic     loadFrame;
    logic     newLine;
    baseSel_e baseSel;
    logic     stepAddr;
  } fetchStrobe_t;

endpackage

// File: rtl/dispFetchCtrl.sv
module dispFetchCtrl
  import dispFetchPkg::*;
#(
  parameter int LINE_W = 11,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              fetchAdv,
  input  logic [CNT_W-1:0]  dwordsPerLine,
  input  logic [LINE_W-1:0] splitLine,
  input  logic              splitEn,
  input  logic              lineDblEn,
  output fetchStrobe_t      strobe,
  output logic              fetchValid,
  output logic              repeatLine
);

  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] nextLine;
  logic              started;
  logic [CNT_W-1:0]  remain;
  logic              splitHit;
  logic              oddRepeat;
  logic              openLine;

  assign openLine  = lineStart && !frameStart;
  assign nextLine  = started ? lineCnt + 1'b1 : '0;
  assign splitHit  = splitEn && (nextLine == splitLine);
  assign oddRepeat = lineDblEn && nextLine[0] && !splitHit;
  assign fetchValid = fetchAdv && !frameStart && !lineStart && (remain != '0);

  always_comb begin
    strobe.loadFrame = frameStart;
    strobe.newLine   = openLine;
    strobe.stepAddr  = fetchValid;
    if (splitHit)       strobe.baseSel = BASE_ZERO;
    else if (!started)  strobe.baseSel = BASE_HOLD;
    else if (oddRepeat) strobe.baseSel = BASE_HOLD;
    else                strobe.baseSel = BASE_ADV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt    <= '0;
      started    <= 1'b0;
      remain     <= '0;
      repeatLine <= 1'b0;
    end else if (frameStart) begin
      lineCnt    <= '0;
      started    <= 1'b0;
      remain     <= '0;
      repeatLine <= 1'b0;
    end else if (lineStart) begin
      lineCnt    <= nextLine;
      started    <= 1'b1;
      remain     <= dwordsPerLine;
      repeatLine <= oddRepeat;
    end else if (fetchValid) begin
      remain <= remain - 1'b1;
    end
  end

  // R3: a line start loads the full fetch credit
  p_credit_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    openLine |=> remain == $past(dwordsPerLine));

  // R3: each granted fetch consumes one credit
  p_credit_drain_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> remain == $past(remain) - 1'b1);

  // R1: frame start clears credit and the repeat flag
  p_frame_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (remain == '0) && !repeatLine);

  // R6: without line doubling a new line never repeats
  p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (openLine && !lineDblEn) |=> !repeatLine);

  // R7: no grant in a cycle carrying a frame or line strobe
  p_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart || lineStart) |-> !fetchValid);

endmodule

// File: rtl/dispFetchPath.sv
module dispFetchPath
  import dispFetchPkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic [ADDR_W-1:0] lineDelta,
  input  logic              chain4En,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_FOUR = ADDR_W'(4);

  logic [ADDR_W-1:0] lineBase;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] newBase;
  logic [ADDR_W-1:0] stepAmt;

  assign stepAmt = chain4En ? STEP_FOUR : STEP_ONE;

  always_comb begin
    unique case (strobe.baseSel)
      BASE_ADV:  newBase = lineBase + lineDelta;
      BASE_ZERO: newBase = '0;
      default:   newBase = lineBase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBase <= '0;
      curAddr  <= '0;
    end else if (strobe.loadFrame) begin
      lineBase <= startOffset;
      curAddr  <= startOffset;
    end else if (strobe.newLine) begin
      lineBase <= newBase;
      curAddr  <= newBase;
    end else if (strobe.stepAddr) begin
      curAddr  <= curAddr + stepAmt;
    end
  end

  assign fetchAddr = curAddr;

  // R1: frame start loads the offset into both address registers
  p_frame_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> (curAddr == $past(startOffset)) && (lineBase == $past(startOffset)));

  // R4: a granted fetch advances by the mode's step
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepAddr && !strobe.loadFrame && !strobe.newLine)
      |=> curAddr == $past(curAddr) + $past(stepAmt));

  // R5: split match starts the line at zero
  p_split_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.newLine && !strobe.loadFrame && strobe.baseSel == BASE_ZERO)
      |=> (curAddr == '0) && (lineBase == '0));

  // R6: a held line restarts from the previous base
  p_hold_base_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.newLine && !strobe.loadFrame && strobe.baseSel == BASE_HOLD)
      |=> curAddr == $past(lineBase));

endmodule

// File: rtl/dispFetchAddr.sv
module dispFetchAddr
  import dispFetchPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LINE_W = 11,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              fetchAdv,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic [ADDR_W-1:0] lineDelta,
  input  logic [CNT_W-1:0]  dwordsPerLine,
  input  logic [LINE_W-1:0] splitLine,
  input  logic              splitEn,
  input  logic              chain4En,
  input  logic              lineDblEn,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic              repeatLine
);

  fetchStrobe_t strobe;

  dispFetchCtrl #(.LINE_W(LINE_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .frameStart(frameStart), .lineStart(lineStart), .fetchAdv(fetchAdv),
    .dwordsPerLine(dwordsPerLine), .splitLine(splitLine),
    .splitEn(splitEn), .lineDblEn(lineDblEn),
    .strobe(strobe), .fetchValid(fetchValid), .repeatLine(repeatLine)
  );

  dispFetchPath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startOffset(startOffset), .lineDelta(lineDelta),
    .chain4En(chain4En), .fetchAddr(fetchAddr)
  );

  // R9: nothing is granted while no line has been opened since reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |=> !fetchValid && !repeatLine && (fetchAddr == '0));

endmodule

// File: tb/dispFetchAddr_test.sv
module dispFetchAddr_test;
  localparam int ADDR_W = 20;
  localparam int LINE_W = 11;
  localparam int CNT_W  = 10;
  localparam int AMASK  = (1 << ADDR_W) - 1;
  localparam int LMASK  = (1 << LINE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, lineStart = 0, fetchAdv = 0;
  logic [ADDR_W-1:0] startOffset = '0, lineDelta = '0;
  logic [CNT_W-1:0]  dwordsPerLine = '0;
  logic [LINE_W-1:0] splitLine = '0;
  logic splitEn = 0, chain4En = 0, lineDblEn = 0;
  logic [ADDR_W-1:0] fetchAddr;
  logic fetchValid, repeatLine;

  always #5 clk = ~clk;

  dispFetchAddr #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .fetchAdv(fetchAdv), .startOffset(startOffset), .lineDelta(lineDelta),
    .dwordsPerLine(dwordsPerLine), .splitLine(splitLine), .splitEn(splitEn),
    .chain4En(chain4En), .lineDblEn(lineDblEn),
    .fetchAddr(fetchAddr), .fetchValid(fetchValid), .repeatLine(repeatLine)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string curReq = "R9";

  // behavioural reference state
  int mBase = 0, mAddr = 0, mLine = 0, mRemain = 0;
  bit mStarted = 0, mRep = 0;

  task automatic chk(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc(bit fs, bit ls, bit fa);
    bit expValid;
    int n, b;
    bit match;
    frameStart = fs; lineStart = ls; fetchAdv = fa;
    #1;
    expValid = fa && !fs && !ls && (mRemain > 0);
    chk(curReq, "fetchValid", int'(fetchValid), int'(expValid));
    chk(curReq, "fetchAddr", int'(fetchAddr), mAddr);
    chk(curReq, "repeatLine", int'(repeatLine), int'(mRep));
    @(posedge clk);
    if (fs) begin
      mBase = int'(startOffset); mAddr = mBase; mLine = 0;
      mStarted = 0; mRemain = 0; mRep = 0;
    end else if (ls) begin
      n = mStarted ? ((mLine + 1) & LMASK) : 0;
      match = splitEn && (n == int'(splitLine));
      if (match) b = 0;
      else if (!mStarted) b = mBase;
      else if (lineDblEn && (n % 2 == 1)) b = mBase;
      else b = (mBase + int'(lineDelta)) & AMASK;
      mRep = lineDblEn && (n % 2 == 1) && !match;
      mBase = b; mAddr = b; mLine = n; mStarted = 1;
      mRemain = int'(dwordsPerLine);
    end else if (expValid) begin
      mAddr = (mAddr + (chain4En ? 4 : 1)) & AMASK;
      mRemain--;
    end
    @(negedge clk);
    frameStart = 0; lineStart = 0; fetchAdv = 0;
  endtask

  // open a line, then issue 'adv' advances with an idle cycle every third one
  task automatic runLine(int adv);
    cyc(0, 1, 0);
    for (int i = 0; i < adv; i++) begin
      cyc(0, 0, 1);
      if (i % 3 == 2) cyc(0, 0, 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9: reset state and no grant before a line opens
    curReq = "R9";
    cyc(0, 0, 1);
    rstN = 1'b1;
    cyc(0, 0, 1);
    cyc(0, 0, 1);

    // R1, R2, R3: plain progressive frame with surplus advances
    curReq = "R1";
    startOffset = 20'h00100; lineDelta = 20'h00040; dwordsPerLine = 10'd5;
    cyc(1, 0, 1);
    chk("R1", "frame offset", int'(fetchAddr), 'h100);
    runLine(7);
    curReq = "R2";
    cyc(0, 1, 0);
    chk("R2", "line1 base", int'(fetchAddr), 'h140);
    curReq = "R3";
    for (int i = 0; i < 7; i++) cyc(0, 0, 1);
    chk("R3", "end of line1", int'(fetchAddr), 'h145);
    runLine(3);
    runLine(6);

    // R4: chain-4 skip
    curReq = "R4";
    chain4En = 1; dwordsPerLine = 10'd6;
    cyc(1, 0, 0);
    runLine(8);
    chk("R4", "chain4 end", int'(fetchAddr), 'h100 + 24);
    runLine(6);
    chain4En = 0;

    // R5: split-screen compare at line 3
    curReq = "R5";
    splitEn = 1; splitLine = 11'd3; dwordsPerLine = 10'd2;
    cyc(1, 0, 0);
    for (int l = 0; l < 6; l++) runLine(2);
    cyc(0, 0, 0);

    // R6: line doubling, with and without a split
    curReq = "R6";
    splitEn = 0; lineDblEn = 1; dwordsPerLine = 10'd3;
    cyc(1, 0, 0);
    for (int l = 0; l < 6; l++) runLine(4);
    cyc(1, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 1, 0);
    chk("R6", "repeat flag odd line", int'(repeatLine), 1);
    chk("R6", "odd line base", int'(fetchAddr), 'h100);
    splitEn = 1; splitLine = 11'd3;
    cyc(0, 1, 0);
    for (int l = 0; l < 4; l++) runLine(3);
    splitEn = 0; lineDblEn = 0;

    // R7: strobe priority
    curReq = "R7";
    startOffset = 20'h00200;
    cyc(1, 1, 1);
    chk("R7", "frame wins", int'(fetchAddr), 'h200);
    cyc(0, 1, 1);
    cyc(0, 1, 1);
    cyc(0, 0, 1);
    cyc(1, 0, 1);
    cyc(0, 0, 1);

    // R8: wrap of step and delta
    curReq = "R8";
    startOffset = 20'hFFFFE; lineDelta = 20'h00010; dwordsPerLine = 10'd4;
    cyc(1, 0, 0);
    runLine(4);
    chk("R8", "step wrap", int'(fetchAddr), 'h00002);
    cyc(0, 1, 0);
    chk("R8", "delta wrap", int'(fetchAddr), 'h0000E);
    runLine(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule